// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End

This block sits at the front of a small 8-bit microcontroller core with separate program and data memories. It keeps a word-addressed program counter and reads 16-bit words from a synchronous program memory. A read is issued in one cycle and its data comes back in the next. Instruction length is decoded inside the fetch stage, so execute gets a ready instruction. While execute works on one instruction, the next word is already being read. A stream of single-word instructions therefore reaches execute at one per clock.

Instructions are one or two words long. For a two-word instruction, the front end keeps the first word and reads the second in the next cycle. It then hands both words over together, tagged with the address of the first. When execute needs several cycles for an instruction, it raises a hold. The presented instruction stays frozen and the word in flight is read again, so no word is lost. A taken branch loads the program counter with the target. It drops whatever was prefetched or half assembled and costs one empty cycle.

A small sequencer with three states drives the block. EMPTY means no read is in flight; it holds only after reset. STREAM means a read is in flight and no first word is held. UPPER means a read is in flight and the first word of a two-word instruction is held. The transitions are:

- fill: EMPTY to STREAM, always.
- split: STREAM to UPPER, when a two-word opener is accepted.
- join: UPPER to STREAM, when the second word is accepted.
- redirect: STREAM or UPPER to STREAM, when a branch is taken.
- Otherwise the sequencer keeps its state.

Top module: `fetch_frontend`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `dec_valid` is low. The first read goes to address 0. The instruction at address 0 appears after the second rising edge following release.
- R2: A run of single-word instructions is presented one per clock, with `dec_pc` rising by one each time.
- R3: A word is the first word of a two-word instruction exactly when its bits 15:12 equal 4'hF (the default mask 16'hF000 and match 16'hF000). `dec_long` is set exactly for such instructions. The second word of a pair is never decoded for length.
- R4: A two-word instruction is presented with `dec_w0` holding the first word, `dec_w1` the second word, and `dec_pc` the first word's address. One empty cycle comes before it. The next instruction follows at `dec_pc`+2.
- R5: While `dec_valid` and `ex_hold` are both high and no branch is taken, all outputs stay unchanged in the next cycle. After the hold drops, the next instruction appears in the following cycle. A hold while `dec_valid` is low has no effect.
- R6: After `br_take`, `dec_valid` is low for one cycle. Both the prefetched word and any held first word are discarded. A single-word instruction at `br_target` is then presented in the next cycle.
- R7: A taken branch wins over `ex_hold`: the frozen instruction is dropped and the target is fetched as in R6.
- R8: The program counter wraps modulo 2^13. A two-word instruction at address 8191 takes its second word from address 0.
- R9: For a single-word instruction, `dec_w1` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 13 | Program memory word address for this cycle's read |
| imem_rdata | input | 16 | Word read at the address issued in the previous cycle |
| ex_hold | input | 1 | Execute is busy with a multi-cycle instruction |
| br_take | input | 1 | Execute redirects the fetch stream |
| br_target | input | 13 | Word address of the redirect |
| dec_valid | output | 1 | An instruction is presented to execute |
| dec_long | output | 1 | The presented instruction is two words |
| dec_pc | output | 13 | Address of the presented instruction's first word |
| dec_w0 | output | 16 | First instruction word |
| dec_w1 | output | 16 | Second instruction word, zero for single-word instructions |

## Verification
The bench builds the block with its default parameters: a 13-bit counter, 16-bit words, and length decode on the top nibble 4'hF. Its program memory repeats every 256 words. Because of that aliasing, a branch to address 8190 reaches the wrap at the top of the address space in a few cycles. A two-word instruction straddling 8191 and 0 shows that the wrap works during assembly. Directed programs mix one- and two-word instructions, so holds and branches land in each of the three sequencer states.

// File: rtl/fe_pkg.sv
package fe_pkg;

    // Sequencer state: whether a read is in flight and whether a first half is held
    typedef enum logic [1:0] {
        FE_EMPTY  = 2'd0,
        FE_STREAM = 2'd1,
        FE_UPPER  = 2'd2
    } fe_state_t;

endpackage

// File: rtl/fe_len_decode.sv
module fe_len_decode #(
    parameter int             IW         = 16,
    parameter logic [IW-1:0]  LONG_MASK  = 16'hF000,
    parameter logic [IW-1:0]  LONG_MATCH = 16'hF000
) (
    input  logic [IW-1:0] word,
    output logic          is_long
);

    assign is_long = ((word & LONG_MASK) == LONG_MATCH);

endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
    import fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      br_take,
    input  logic      slot_free,
    input  logic      word_long,
    output fe_state_t state,
    output logic      take,
    output logic      reissue
);

    fe_state_t state_q;
    fe_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FE_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FE_EMPTY: begin
                state_d = FE_STREAM;                       // fill
            end
            FE_STREAM: begin
                if (br_take) begin
                    state_d = FE_STREAM;                   // redirect
                end else if (slot_free && word_long) begin
                    state_d = FE_UPPER;                    // split
                end
            end
            FE_UPPER: begin
                if (br_take || slot_free) begin
                    state_d = FE_STREAM;                   // redirect or join
                end
            end
            default: begin
                state_d = FE_EMPTY;
            end
        endcase
    end

    // Outputs
    always_comb begin
        take    = 1'b0;
        reissue = 1'b0;
        unique case (state_q)
            FE_EMPTY: begin
                take    = 1'b0;
                reissue = 1'b0;
            end
            FE_STREAM, FE_UPPER: begin
                take    = slot_free && !br_take;
                reissue = !slot_free && !br_take;
            end
            default: begin
                take    = 1'b0;
                reissue = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/fe_pc.sv
module fe_pc #(
    parameter int PC_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_take,
    input  logic [PC_W-1:0] br_target,
    input  logic            reissue,
    output logic [PC_W-1:0] imem_addr,
    output logic [PC_W-1:0] req_pc
);

    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] rq_q;

    // Address select: redirect, repeat the in-flight read, or continue
    always_comb begin
        if (br_take) begin
            imem_addr = br_target;
        end else if (reissue) begin
            imem_addr = rq_q;
        end else begin
            imem_addr = pc_q;
        end
    end

    // Counter wraps naturally at 2**PC_W
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            rq_q <= '0;
        end else begin
            rq_q <= imem_addr;
            pc_q <= imem_addr + PC_ONE;
        end
    end

    assign req_pc = rq_q;

endmodule

// File: rtl/fe_issue.sv
module fe_issue #(
    parameter int PC_W = 13,
    parameter int IW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            in_upper,
    input  logic            word_long,
    input  logic            br_take,
    input  logic            slot_free,
    input  logic [IW-1:0]   word,
    input  logic [PC_W-1:0] req_pc,
    output logic            dec_valid,
    output logic            dec_long,
    output logic [PC_W-1:0] dec_pc,
    output logic [IW-1:0]   dec_w0,
    output logic [IW-1:0]   dec_w1
);

    logic [IW-1:0]   half_w;
    logic [PC_W-1:0] half_pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_long  <= 1'b0;
            dec_pc    <= '0;
            dec_w0    <= '0;
            dec_w1    <= '0;
            half_w    <= '0;
            half_pc   <= '0;
        end else if (br_take) begin
            dec_valid <= 1'b0;
        end else if (take) begin
            if (in_upper) begin
                dec_valid <= 1'b1;
                dec_long  <= 1'b1;
                dec_pc    <= half_pc;
                dec_w0    <= half_w;
                dec_w1    <= word;
            end else if (word_long) begin
                half_w    <= word;
                half_pc   <= req_pc;
                dec_valid <= 1'b0;
            end else begin
                dec_valid <= 1'b1;
                dec_long  <= 1'b0;
                dec_pc    <= req_pc;
                dec_w0    <= word;
                dec_w1    <= '0;
            end
        end else if (slot_free) begin
            dec_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend
    import fe_pkg::*;
#(
    parameter int            PC_W       = 13,
    parameter int            IW         = 16,
    parameter logic [IW-1:0] LONG_MASK  = 16'hF000,
    parameter logic [IW-1:0] LONG_MATCH = 16'hF000
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] imem_addr,
    input  logic [IW-1:0]   imem_rdata,
    input  logic            ex_hold,
    input  logic            br_take,
    input  logic [PC_W-1:0] br_target,
    output logic            dec_valid,
    output logic            dec_long,
    output logic [PC_W-1:0] dec_pc,
    output logic [IW-1:0]   dec_w0,
    output logic [IW-1:0]   dec_w1
);

    fe_state_t       state;
    logic            take;
    logic            reissue;
    logic            word_long;
    logic            slot_free;
    logic [PC_W-1:0] req_pc;

    // Execute releases the slot unless it is holding a valid instruction
    assign slot_free = !dec_valid || !ex_hold;

    fe_len_decode #(
        .IW         (IW),
        .LONG_MASK  (LONG_MASK),
        .LONG_MATCH (LONG_MATCH)
    ) u_len (
        .word    (imem_rdata),
        .is_long (word_long)
    );

    fe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_take   (br_take),
        .slot_free (slot_free),
        .word_long (word_long),
        .state     (state),
        .take      (take),
        .reissue   (reissue)
    );

    fe_pc #(
        .PC_W (PC_W)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_take   (br_take),
        .br_target (br_target),
        .reissue   (reissue),
        .imem_addr (imem_addr),
        .req_pc    (req_pc)
    );

    fe_issue #(
        .PC_W (PC_W),
        .IW   (IW)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .in_upper  (state == FE_UPPER),
        .word_long (word_long),
        .br_take   (br_take),
        .slot_free (slot_free),
        .word      (imem_rdata),
        .req_pc    (req_pc),
        .dec_valid (dec_valid),
        .dec_long  (dec_long),
        .dec_pc    (dec_pc),
        .dec_w0    (dec_w0),
        .dec_w1    (dec_w1)
    );

endmodule

// File: rtl/fetch_frontend_chk.sv
module fetch_frontend_chk #(
    parameter int            PC_W       = 13,
    parameter int            IW         = 16,
    parameter logic [IW-1:0] LONG_MASK  = 16'hF000,
    parameter logic [IW-1:0] LONG_MATCH = 16'hF000
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic            ex_hold,
    input logic            br_take,
    input logic [PC_W-1:0] br_target,
    input logic            dec_valid,
    input logic            dec_long,
    input logic [PC_W-1:0] dec_pc,
    input logic [IW-1:0]   dec_w0,
    input logic [IW-1:0]   dec_w1
);

    localparam logic [PC_W-1:0] C_ONE = {{(PC_W-1){1'b0}}, 1'b1};
    localparam logic [PC_W-1:0] C_TWO = {{(PC_W-2){1'b0}}, 2'b10};

    logic [PC_W-1:0] step_pc;
    logic [PC_W-1:0] tgt_next;

    assign step_pc  = dec_pc + (dec_long ? C_TWO : C_ONE);
    assign tgt_next = br_target + C_ONE;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !dec_valid);

    assert_first_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !br_take) |-> (imem_addr == '0));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid && !ex_hold && !br_take) && dec_valid) |-> (dec_pc == $past(step_pc)));

    assert_len_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_long == ((dec_w0 & LONG_MASK) == LONG_MATCH)));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ex_hold && !br_take) |=>
            (dec_valid && $stable(dec_pc) && $stable(dec_w0) && $stable(dec_w1) && $stable(dec_long)));

    assert_branch_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_take |=> !dec_valid);

    assert_branch_next_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take ##1 !br_take) |-> (imem_addr == $past(tgt_next)));

    assert_branch_over_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && ex_hold && dec_valid) |=> !dec_valid);

    assert_short_w1_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_long) |-> (dec_w1 == '0));

endmodule

bind fetch_frontend fetch_frontend_chk #(
    .PC_W       (PC_W),
    .IW         (IW),
    .LONG_MASK  (LONG_MASK),
    .LONG_MATCH (LONG_MATCH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .ex_hold   (ex_hold),
    .br_take   (br_take),
    .br_target (br_target),
    .dec_valid (dec_valid),
    .dec_long  (dec_long),
    .dec_pc    (dec_pc),
    .dec_w0    (dec_w0),
    .dec_w1    (dec_w1)
);

// File: tb/fetch_frontend_tb.sv
module fetch_frontend_tb;

    localparam int PC_W = 13;
    localparam int IW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] imem_addr;
    logic [IW-1:0]   imem_rdata = '0;
    logic            ex_hold = 1'b0;
    logic            br_take = 1'b0;
    logic [PC_W-1:0] br_target = '0;
    logic            dec_valid;
    logic            dec_long;
    logic [PC_W-1:0] dec_pc;
    logic [IW-1:0]   dec_w0;
    logic [IW-1:0]   dec_w1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [IW-1:0] prog [0:255];

    always #10 clk = ~clk;

    // Synchronous program memory, aliased every 256 words
    always @(posedge clk) imem_rdata <= prog[imem_addr[7:0]];

    fetch_frontend u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .ex_hold    (ex_hold),
        .br_take    (br_take),
        .br_target  (br_target),
        .dec_valid  (dec_valid),
        .dec_long   (dec_long),
        .dec_pc     (dec_pc),
        .dec_w0     (dec_w0),
        .dec_w1     (dec_w1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic exp_instr(input string req, input logic [PC_W-1:0] pc, input bit lng);
        logic [PC_W-1:0] nx;
        logic [IW-1:0]   e0;
        logic [IW-1:0]   e1;
        nx = pc + 13'd1;
        e0 = prog[pc[7:0]];
        e1 = lng ? prog[nx[7:0]] : 16'h0000;
        check(dec_valid === 1'b1, req, "valid", 32'(dec_valid), 32'd1);
        check(dec_pc === pc, req, "pc", 32'(dec_pc), 32'(pc));
        check(dec_long === lng, req, "long", 32'(dec_long), 32'(lng));
        check(dec_w0 === e0, req, "w0", 32'(dec_w0), 32'(e0));
        check(dec_w1 === e1, req, "w1", 32'(dec_w1), 32'(e1));
    endtask

    task automatic exp_bubble(input string req);
        check(dec_valid === 1'b0, req, "bubble", 32'(dec_valid), 32'd0);
    endtask

    task automatic fill_short();
        for (int i = 0; i < 256; i++) prog[i] = 16'h1000 + 16'(i);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ex_hold = 1'b0;
        br_take = 1'b0;
        br_target = '0;
        repeat (3) @(negedge clk);
        check(dec_valid === 1'b0, "R1", "valid in reset", 32'(dec_valid), 32'd0);
        check(imem_addr === '0, "R1", "addr in reset", 32'(imem_addr), 32'd0);
        rst_n = 1'b1;
    endtask

    // R1: reset state and first fetch timing
    task automatic t_reset();
        fill_short();
        do_reset();
        step();
        exp_bubble("R1");
        check(imem_addr === 13'd1, "R1", "second addr", 32'(imem_addr), 32'd1);
        step();
        exp_instr("R1", 13'd0, 1'b0);
    endtask

    // R2: back-to-back single-word stream
    task automatic t_stream();
        fill_short();
        do_reset();
        step();
        for (int k = 0; k < 12; k++) begin
            step();
            exp_instr("R2", 13'(k), 1'b0);
        end
    endtask

    // R3, R4, R9: mixed lengths; second word with opener pattern is not decoded
    task automatic t_long();
        fill_short();
        prog[1] = 16'hF001;
        prog[2] = 16'hF5A5;
        prog[4] = 16'hFABC;
        prog[5] = 16'h0123;
        do_reset();
        step();
        step(); exp_instr("R9", 13'd0, 1'b0);
        step(); exp_bubble("R4");
        step(); exp_instr("R3", 13'd1, 1'b1);
        step(); exp_instr("R4", 13'd3, 1'b0);
        step(); exp_bubble("R4");
        step(); exp_instr("R4", 13'd4, 1'b1);
        step(); exp_instr("R4", 13'd6, 1'b0);
    endtask

    // R5: hold on short and long instructions, hold during a bubble
    task automatic t_hold();
        fill_short();
        prog[4] = 16'hF044;
        prog[5] = 16'h7777;
        do_reset();
        step();
        step(); exp_instr("R5", 13'd0, 1'b0);
        ex_hold = 1'b1;
        repeat (3) begin
            step(); exp_instr("R5", 13'd0, 1'b0);
        end
        ex_hold = 1'b0;
        step(); exp_instr("R5", 13'd1, 1'b0);
        step(); exp_instr("R5", 13'd2, 1'b0);
        step(); exp_instr("R5", 13'd3, 1'b0);
        step(); exp_bubble("R5");
        ex_hold = 1'b1;
        step(); exp_instr("R5", 13'd4, 1'b1);
        step(); exp_instr("R5", 13'd4, 1'b1);
        ex_hold = 1'b0;
        step(); exp_instr("R5", 13'd6, 1'b0);
        step(); exp_instr("R5", 13'd7, 1'b0);
    endtask

    // R6: redirect in stream, to a two-word target, and while a half is held
    task automatic t_branch();
        fill_short();
        prog[50] = 16'hF050;
        prog[51] = 16'h5151;
        prog[60] = 16'hF060;
        do_reset();
        step();
        step(); exp_instr("R6", 13'd0, 1'b0);
        step(); exp_instr("R6", 13'd1, 1'b0);
        br_take = 1'b1; br_target = 13'd40;
        step(); exp_bubble("R6");
        br_take = 1'b0;
        step(); exp_instr("R6", 13'd40, 1'b0);
        step(); exp_instr("R6", 13'd41, 1'b0);
        br_take = 1'b1; br_target = 13'd50;
        step(); exp_bubble("R6");
        br_take = 1'b0;
        step(); exp_bubble("R6");
        step(); exp_instr("R6", 13'd50, 1'b1);
        step(); exp_instr("R6", 13'd52, 1'b0);
        br_take = 1'b1; br_target = 13'd60;
        step(); exp_bubble("R6");
        br_take = 1'b0;
        step(); exp_bubble("R6");
        br_take = 1'b1; br_target = 13'd40;
        step(); exp_bubble("R6");
        br_take = 1'b0;
        step(); exp_instr("R6", 13'd40, 1'b0);
    endtask

    // R7: branch while execute holds
    task automatic t_hold_branch();
        fill_short();
        do_reset();
        step();
        step(); exp_instr("R7", 13'd0, 1'b0);
        ex_hold = 1'b1;
        br_take = 1'b1; br_target = 13'd20;
        step(); exp_bubble("R7");
        br_take = 1'b0;
        step(); exp_instr("R7", 13'd20, 1'b0);
        step(); exp_instr("R7", 13'd20, 1'b0);
        ex_hold = 1'b0;
        step(); exp_instr("R7", 13'd21, 1'b0);
    endtask

    // R8: wrap at the top of the address space, including a straddling pair
    task automatic t_wrap();
        fill_short();
        prog[255] = 16'hF0FF;
        prog[0]   = 16'h2222;
        do_reset();
        step();
        step(); exp_instr("R8", 13'd0, 1'b0);
        br_take = 1'b1; br_target = 13'd8190;
        step(); exp_bubble("R8");
        br_take = 1'b0;
        step(); exp_instr("R8", 13'd8190, 1'b0);
        step(); exp_bubble("R8");
        step(); exp_instr("R8", 13'd8191, 1'b1);
        step(); exp_instr("R8", 13'd1, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        fill_short();
        t_reset();
        t_stream();
        t_long();
        t_hold();
        t_branch();
        t_hold_branch();
        t_wrap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule